// File: doc/BRIEF.md
# SD Card Clock Divider Control

This block derives the SD card clock from the base clock. A 16-bit control word written by the host holds a divider code, an internal-clock enable and a card-clock enable. A read-only settle flag is set once the internal clock has had time to become stable. The card clock runs only after software has raised the internal enable, seen the settle flag and then raised the card enable. The block drives a toggled card clock level and a single-cycle tick that marks each rising card-clock edge. The tick serves as a clock enable for logic running on the base clock.

A divider code N greater than zero gives a card clock period of 2N base cycles. A code of zero selects the undivided base clock, which appears as a tick in every cycle. The code is split across two register fields: the low eight bits sit in the upper byte, and the top two bits sit in bits [7:6].

A mode input selects between two controller generations. The newer generation accepts any code up to 1023, which is a divisor of up to 2046. The older generation uses only the 8-bit field and accepts only power-of-two divisors up to 256. In that mode any other code is rounded up.

Top module: `sd_clk_div_ctrl`

## Requirements
- R1: After reset, ctrl_o reads 0 and card_clk_o and card_tick_o are low.
- R2: The ctrl_o layout is as follows. Bit 0 is the internal enable. Bit 2 is the card enable. Bit 1 is the settle flag, and writes to it are ignored. Code bits [7:0] are in [15:8]. Code bits [9:8] are in [7:6]. Bits [5:3] read 0.
- R3: After a write that sets bit 0, the settle flag reads 1 exactly STABLE_DLY cycles later. It reads 0 from the cycle after any write that clears bit 0.
- R4: card_clk_o and card_tick_o stay low in every cycle in which the card enable or the settle flag reads 0.
- R5: With a code N > 0 and the clock running, the card clock has a period of 2N base cycles with N cycles high. card_tick_o is high for exactly one cycle per period, in the first high cycle.
- R6: With a code of 0 and the clock running, card_tick_o is high in every cycle and card_clk_o stays low.
- R7: In newer mode (new_mode_i = 1), all ten code bits take effect. For example, code 513 gives a period of 1026.
- R8: In older mode (new_mode_i = 0), writes to bits [7:6] are ignored and those bits read 0.
- R9: In older mode, a code that is not a power of two is rounded up to the next power of two, with a ceiling of 128 (divisor 256). Codes 5, 4 and 200 therefore give periods of 16, 8 and 256.
- R10: A code change while the clock runs takes effect only at the end of a low phase. Every high or low phase therefore lasts the full old or the full new half-period.
- R11: Writing 0 to the register stops the card clock. From the cycle after the write, both outputs are low and ctrl_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| new_mode_i | input | 1 | 1 selects newer generation (even divisors to 2046), 0 selects older (powers of two to 256) |
| wr_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 16 | Control word to write |
| ctrl_o | output | 16 | Control word readback, including the settle flag |
| card_clk_o | output | 1 | Divided, gated card clock level |
| card_tick_o | output | 1 | One-cycle pulse at each card clock rising edge |

## Verification
The assertions check four properties on every cycle. The outputs stay silent unless both the card enable and the settle flag are set. The settle flag rises only after the enable has been held for the full settle delay. Every card-clock rising edge carries a tick. In older mode, every high phase has a power-of-two length. Only the bench scenarios show the exact periods for given codes, the rounding and clamping values, the bypass behaviour, the register field layout and the phase lengths around a divider change made while the clock runs.

// File: rtl/sd_clk_pkg.sv
package sd_clk_pkg;
  localparam int unsigned SDC_REG_W  = 16;
  localparam int unsigned SDC_CODE_W = 10;
  localparam int unsigned SDC_LO_W   = 8;
  localparam int unsigned SDC_HI_W   = SDC_CODE_W - SDC_LO_W;
  localparam int unsigned SDC_PAD_W  = SDC_REG_W - SDC_CODE_W - 3;

  typedef struct packed {
    logic [SDC_CODE_W-1:0] code;
    logic                  card_en;
    logic                  int_en;
  } sdc_cfg_t;

  // smallest power of two >= n, clamped to 2**(LO_W-1); 0 stays 0
  function automatic logic [SDC_CODE_W-1:0] sdc_round_pow2(input logic [SDC_LO_W-1:0] n);
    logic [SDC_CODE_W-1:0] r;
    r = '0;
    if (n != '0) begin
      r = SDC_CODE_W'(1) << (SDC_LO_W - 1);
      for (int i = SDC_LO_W - 1; i >= 0; i--) begin
        if ((SDC_CODE_W'(1) << i) >= SDC_CODE_W'(n)) r = SDC_CODE_W'(1) << i;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sd_clk_reg.sv
module sd_clk_reg
  import sd_clk_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 new_mode_i,
  input  logic                 wr_i,
  input  logic [SDC_REG_W-1:0] wdata_i,
  input  logic                 stable_i,
  output sdc_cfg_t             cfg_o,
  output sdc_cfg_t             cfg_nxt_o,
  output logic [SDC_REG_W-1:0] rdata_o
);
  localparam int unsigned HI_POS = SDC_REG_W - SDC_LO_W - SDC_HI_W;

  sdc_cfg_t cfg_q;

  always_comb begin
    cfg_nxt_o = cfg_q;
    if (wr_i) begin
      cfg_nxt_o.int_en  = wdata_i[0];
      cfg_nxt_o.card_en = wdata_i[2];
      cfg_nxt_o.code[SDC_LO_W-1:0] = wdata_i[SDC_REG_W-1 -: SDC_LO_W];
      // older generation has no upper code bits
      cfg_nxt_o.code[SDC_CODE_W-1:SDC_LO_W] =
        new_mode_i ? wdata_i[HI_POS +: SDC_HI_W] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_nxt_o;
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {cfg_q.code[SDC_LO_W-1:0], cfg_q.code[SDC_CODE_W-1:SDC_LO_W],
                    {SDC_PAD_W{1'b0}}, cfg_q.card_en, stable_i, cfg_q.int_en};
endmodule

// File: rtl/sd_clk_settle.sv
module sd_clk_settle #(
  parameter int unsigned STABLE_DLY = 8,
  localparam int unsigned CNT_W = $clog2(STABLE_DLY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_en_i,
  input  logic int_en_nxt_i,
  output logic stable_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!int_en_i || !int_en_nxt_i) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(STABLE_DLY - 1)) stable_q <= 1'b1;
    end
  end

  assign stable_o = stable_q;
endmodule

// File: rtl/sd_clk_gen.sv
module sd_clk_gen #(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_nxt_i,
  output logic              clk_o,
  output logic              tick_o
);
  logic [CODE_W-1:0] act_q, cnt_q;
  logic              clk_q, tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (!run_i) begin
      act_q  <= code_nxt_i;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (act_q == '0) begin
      // bypass: every base cycle is a card edge
      act_q  <= code_nxt_i;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      tick_q <= 1'b1;
    end else begin
      tick_q <= 1'b0;
      if (cnt_q == act_q - 1'b1) begin
        cnt_q <= '0;
        if (clk_q) begin
          clk_q <= 1'b0;
        end else if (code_nxt_i == '0) begin
          act_q <= '0;
        end else begin
          // new code only picked up at end of low phase
          act_q  <= code_nxt_i;
          clk_q  <= 1'b1;
          tick_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clk_o  = clk_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/sd_clk_div_ctrl.sv
module sd_clk_div_ctrl
  import sd_clk_pkg::*;
#(
  parameter int unsigned STABLE_DLY = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 new_mode_i,
  input  logic                 wr_i,
  input  logic [SDC_REG_W-1:0] wdata_i,
  output logic [SDC_REG_W-1:0] ctrl_o,
  output logic                 card_clk_o,
  output logic                 card_tick_o
);
  sdc_cfg_t              cfg, cfg_nxt;
  logic                  stable;
  logic                  run;
  logic [SDC_CODE_W-1:0] eff_nxt;
  logic                  gen_clk, gen_tick;

  sd_clk_reg i_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .new_mode_i (new_mode_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .stable_i   (stable),
    .cfg_o      (cfg),
    .cfg_nxt_o  (cfg_nxt),
    .rdata_o    (ctrl_o)
  );

  sd_clk_settle #(.STABLE_DLY(STABLE_DLY)) i_settle (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .int_en_i     (cfg.int_en),
    .int_en_nxt_i (cfg_nxt.int_en),
    .stable_o     (stable)
  );

  always_comb begin
    if (new_mode_i) eff_nxt = cfg_nxt.code;
    else            eff_nxt = sdc_round_pow2(cfg_nxt.code[SDC_LO_W-1:0]);
  end

  assign run = cfg.card_en & stable;

  sd_clk_gen #(.CODE_W(SDC_CODE_W)) i_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .code_nxt_i (eff_nxt),
    .clk_o      (gen_clk),
    .tick_o     (gen_tick)
  );

  assign card_clk_o  = gen_clk & run;
  assign card_tick_o = gen_tick & run;
endmodule

// File: rtl/sd_clk_div_chk.sv
module sd_clk_div_chk
  import sd_clk_pkg::*;
#(
  parameter int unsigned STABLE_DLY = 8,
  localparam int unsigned EW = $clog2(STABLE_DLY + 2)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 new_mode_i,
  input logic [SDC_REG_W-1:0] ctrl_o,
  input logic                 card_clk_o,
  input logic                 card_tick_o
);
  logic [EW-1:0]         en_cnt;
  logic [SDC_CODE_W:0]   hi_len;
  logic                  prev_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_cnt  <= '0;
      hi_len  <= '0;
      prev_hi <= 1'b0;
    end else begin
      if (!ctrl_o[0])                       en_cnt <= '0;
      else if (en_cnt != EW'(STABLE_DLY + 1)) en_cnt <= en_cnt + 1'b1;
      if (card_clk_o) hi_len <= (&hi_len) ? hi_len : hi_len + 1'b1;
      else            hi_len <= '0;
      prev_hi <= card_clk_o;
    end
  end

  assert_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o[2] && ctrl_o[1]) |-> (!card_clk_o && !card_tick_o));

  assert_settle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[1]) |-> (ctrl_o[0] && en_cnt == EW'(STABLE_DLY)));

  assert_stable_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[0] |-> !ctrl_o[1]);

  assert_tick_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_clk_o) |-> card_tick_o);

  assert_pow2_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_hi && !card_clk_o && ctrl_o[2] && ctrl_o[1] && !new_mode_i)
      |-> $countones(hi_len) == 1);
endmodule

bind sd_clk_div_ctrl sd_clk_div_chk #(.STABLE_DLY(STABLE_DLY)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .new_mode_i  (new_mode_i),
  .ctrl_o      (ctrl_o),
  .card_clk_o  (card_clk_o),
  .card_tick_o (card_tick_o)
);

// File: tb/test_sd_clk_div_ctrl.sv
`timescale 1ns/1ps
module test_sd_clk_div_ctrl;
  localparam int DLY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        new_mode = 1'b1;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] ctrl;
  logic        card_clk, card_tick;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sd_clk_div_ctrl #(.STABLE_DLY(DLY)) i_sd_clk_div_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .new_mode_i  (new_mode),
    .wr_i        (wr),
    .wdata_i     (wdata),
    .ctrl_o      (ctrl),
    .card_clk_o  (card_clk),
    .card_tick_o (card_tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic start(input logic [15:0] wd);
    wr_reg(16'h0000);
    wr_reg(wd | 16'h0001);
    repeat (DLY + 2) @(negedge clk);
    wr_reg(wd | 16'h0005);
  endtask

  task automatic meas(output int per, output int hi);
    int g = 0;
    while (!card_tick && g < 5000) begin @(negedge clk); g++; end
    per = 0; hi = 0;
    do begin
      if (card_clk) hi++;
      @(negedge clk); per++;
    end while (!card_tick && per < 5000);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl, 0);
    chk("R1 clk", card_clk, 0);
    chk("R1 tick", card_tick, 0);
  endtask

  task automatic t_settle;
    wr_reg(16'h0002);
    chk("R2 settle flag read-only", ctrl, 16'h0000);
    wr_reg(16'h0001);
    repeat (DLY - 1) @(negedge clk);
    chk("R3 not yet settled", ctrl, 16'h0001);
    @(negedge clk);
    chk("R3 settled", ctrl, 16'h0003);
    wr_reg(16'h0000);
    chk("R3 flag drops at once", ctrl, 16'h0000);
  endtask

  task automatic t_gate;
    bit seen = 1'b0;
    wr_reg(16'h0304);
    repeat (40) begin @(negedge clk); if (card_clk || card_tick) seen = 1'b1; end
    chk("R4 no clock without settle", seen, 0);
    chk("R4 readback", ctrl, 16'h0304);
  endtask

  task automatic t_div3;
    int per, hi;
    start(16'h0300);
    chk("R2 readback", ctrl, 16'h0307);
    meas(per, hi);
    chk("R5 period N=3", per, 6);
    chk("R5 high N=3", hi, 3);
  endtask

  task automatic t_wide;
    int per, hi;
    start(16'h0180);  // code 0x201
    chk("R2 R7 split field", ctrl, 16'h0187);
    meas(per, hi);
    chk("R7 period 513", per, 1026);
    chk("R7 high 513", hi, 513);
  endtask

  task automatic t_bypass;
    int nt = 0, nc = 0;
    start(16'h0000);
    repeat (2) @(negedge clk);
    repeat (20) begin
      if (card_tick) nt++;
      if (card_clk) nc++;
      @(negedge clk);
    end
    chk("R6 tick every cycle", nt, 20);
    chk("R6 clk low", nc, 0);
  endtask

  task automatic t_change;
    int per, hi, len, bad;
    logic v;
    start(16'h0200);
    meas(per, hi);
    chk("R5 period N=2", per, 4);
    wr_reg(16'h0405);
    v = card_clk;
    while (card_clk == v) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      len = 0; v = card_clk;
      while (card_clk == v && len < 100) begin len++; @(negedge clk); end
      if (len != 2 && len != 4) bad++;
    end
    chk("R10 no runt phase", bad, 0);
    meas(per, hi);
    chk("R10 new period", per, 8);
  endtask

  task automatic t_old;
    int per, hi;
    wr_reg(16'h0000);
    new_mode = 1'b0;
    start(16'h05C0);
    chk("R8 upper code bits ignored", ctrl, 16'h0507);
    meas(per, hi);
    chk("R9 code 5 rounds to 8", per, 16);
    start(16'h0400);
    meas(per, hi);
    chk("R9 code 4 exact", per, 8);
    start(16'hC800);
    meas(per, hi);
    chk("R9 code 200 clamps", per, 256);
    wr_reg(16'h0000);
    new_mode = 1'b1;
  endtask

  task automatic t_stop;
    int per, hi;
    start(16'h0100);
    meas(per, hi);
    chk("R5 period N=1", per, 2);
    wr_reg(16'h0000);
    chk("R11 ctrl zero", ctrl, 0);
    chk("R11 clk low", card_clk, 0);
    chk("R11 tick low", card_tick, 0);
    start(16'h0100);
    meas(per, hi);
    wr_reg(16'h0104);
    chk("R3 flag drops with enable", ctrl, 16'h0104);
    chk("R4 clk low after drop", card_clk | card_tick, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_settle();
    t_gate();
    t_div3();
    t_wide();
    t_bypass();
    t_change();
    t_old();
    t_stop();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule